// File: doc/BRIEF.md
# Programmable Serial Waveform Sequencer

This block generates the pin activity of a serial bus from a short program rather than from a fixed shifter. The host fills a 32-word instruction memory, preloads a 16-bit address shift register and a 16-bit data shift register, and starts the engine at a chosen program counter. From then on the engine executes one instruction per bit-clock period. An instruction can set the clock, data and select levels, toggle the clock, shift a register in or out, branch on the data-in pin, or stop. The bit clock is the system clock divided by a programmable prescale value plus one.

When a stop instruction executes, the engine drops busy, records the address of the stop instruction and latches a completion flag in a two-bit interrupt status. A start whose program counter does not fit in six bits is refused and latches the second status flag instead. Writing ones to the clear input removes status flags, and the interrupt output is the OR of the status flags masked by the enable input.

The controller has three states: `ST_IDLE` (not busy, waiting for start), `ST_STEP` (one instruction per bit-clock tick) and `ST_REPEAT` (remaining periods of a counted toggle or shift). The transitions are: IDLE to STEP on an accepted start; IDLE stays in IDLE on a refused start; STEP to REPEAT when a toggle or shift has a count above one; REPEAT to STEP after the last counted period, with the program counter advanced; STEP to IDLE on stop.

Top module: `wave_seq`

## Requirements
- R1: After reset busy is 0, the clock and data-out levels are 0, the select level is 1, the data pin is not driven and both interrupt status bits are 0.
- R2: A start in idle with start_pc bits 7:6 both zero makes busy 1 on the next cycle and loads the program counter from start_pc bits 5:0; any start_pc of 64 or above is refused, busy stays 0 and status bit 1 is set.
- R3: With prescale value P, one instruction step takes P+1 cycles; a run of k steps, the stop included, clears busy exactly k*(P+1) cycles after the clock edge that accepted start.
- R4: In an instruction word, bit 0 is the clock level, bit 1 the data-out level, bit 2 the select level (1 = high) and bit 3 the data pin direction (1 = drive); opcode bits 7:5 equal to 0 (and the unused value 3) apply all four levels in one step.
- R5: Opcode 1 inverts the current clock level once per step for the count in bits 15:8 (a count of 0 acts as 1), while bits 1, 2 and 3 set data, select and direction.
- R6: Opcode 2 shifts the register chosen by bit 4 (1 = data, 0 = address) left by one bit per step for the count in bits 15:8 (0 acts as 1), clock taken from bit 0; in drive mode data-out shows the register MSB before each shift and zero fills the LSB, in input mode the data-in pin fills the LSB; the other register is untouched.
- R7: Opcode 4 branches to the target in bits 13:8 when data-in is 0, opcode 5 when data-in is 1; otherwise the program counter advances by one. The memory is indexed by the low 5 bits of the program counter.
- R8: Opcode 6 always branches to the target; every non-branch, non-stop step advances the program counter with the low 5 bits wrapping from 31 to 0.
- R9: Opcode 7 clears busy, reports its own 6-bit address on stop_pc, sets status bit 0 and leaves all pin levels unchanged; while idle the pin levels hold.
- R10: irq is the OR of status masked by irq_en; a 1 on a bit of irq_clr clears that status bit, and a flag set in the same cycle wins.
- R11: Instruction writes take effect only while ram_wr_en is 1; shift register loads are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ram_wr_en | input | 1 | Instruction memory write permission |
| prog_we | input | 1 | Instruction write strobe |
| prog_addr | input | 5 | Instruction write address |
| prog_wdata | input | 16 | Instruction word |
| ld_addr_we | input | 1 | Load strobe for the address shift register |
| ld_data_we | input | 1 | Load strobe for the data shift register |
| ld_value | input | 16 | Value for either load |
| start | input | 1 | Start request |
| start_pc | input | 8 | Start program counter |
| prediv | input | 8 | Bit-clock prescale value P |
| din | input | 1 | Serial data-in pin |
| irq_en | input | 2 | Interrupt enable mask |
| irq_clr | input | 2 | Write-1-to-clear for status |
| sclk | output | 1 | Serial clock level |
| sdo | output | 1 | Serial data-out level |
| sdo_oe | output | 1 | Data pin drive enable |
| cs | output | 1 | Select level |
| busy | output | 1 | Engine running |
| addr_q | output | 16 | Address shift register |
| data_q | output | 16 | Data shift register |
| stop_pc | output | 6 | Address of the last stop executed |
| irq_status | output | 2 | Bit 0 done, bit 1 refused start |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 32 instruction words, 16-bit words and shift registers, a 6-bit program counter and an 8-bit prescaler. At that size it sweeps prescale values 0 to 3 against shift counts 1 to 5, toggle counts 0 to 4, input shifts up to the full register width with both data-in levels, and every branch opcode against both data-in levels, so each run's length, final levels and register contents follow from closed-form arithmetic. The wrap from word 31, a start above 31 that aliases into the memory, refused starts and loads during a run are all reached directly.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
    typedef enum logic [2:0] {
        OP_DIRECT = 3'd0,
        OP_TOGGLE = 3'd1,
        OP_SHIFT  = 3'd2,
        OP_RSVD   = 3'd3,
        OP_BRZ    = 3'd4,
        OP_BRO    = 3'd5,
        OP_JUMP   = 3'd6,
        OP_HALT   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_REPEAT = 2'd2
    } state_e;
endpackage

// File: rtl/wseq_iram.sv
module wseq_iram #(
    parameter int DEPTH = 32,
    parameter int IW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wr_allow,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    logic [IW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && wr_allow)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wseq_prescale.sv
module wseq_prescale #(
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [PSW-1:0] div,
    output logic           tick
);
    logic [PSW-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + PSW'(1);
    end
endmodule

// File: rtl/wseq_shreg.sv
module wseq_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         fill,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (shift)
            q <= {q[W-2:0], fill};
        else if (load)
            q <= load_val;
    end
endmodule

// File: rtl/wave_seq.sv
module wave_seq
    import wseq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IW    = 16,
    parameter int RW    = 16,
    parameter int PCW   = 6,
    parameter int SPW   = 8,
    parameter int PSW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = IW - 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ram_wr_en,
    input  logic           prog_we,
    input  logic [AW-1:0]  prog_addr,
    input  logic [IW-1:0]  prog_wdata,
    input  logic           ld_addr_we,
    input  logic           ld_data_we,
    input  logic [RW-1:0]  ld_value,
    input  logic           start,
    input  logic [SPW-1:0] start_pc,
    input  logic [PSW-1:0] prediv,
    input  logic           din,
    input  logic [1:0]     irq_en,
    input  logic [1:0]     irq_clr,
    output logic           sclk,
    output logic           sdo,
    output logic           sdo_oe,
    output logic           cs,
    output logic           busy,
    output logic [RW-1:0]  addr_q,
    output logic [RW-1:0]  data_q,
    output logic [PCW-1:0] stop_pc,
    output logic [1:0]     irq_status,
    output logic           irq
);
    state_e         state, state_n;
    logic [PCW-1:0] pc, pc_n, pc_inc, tgt;
    logic [CW-1:0]  rep, rep_n, cnt_f;
    logic           sclk_n, sdo_n, cs_n, oe_n;
    logic           sh_en, halt, reject, tick;
    logic [IW-1:0]  instr;
    op_e            op;
    logic           sel;
    logic           sel_msb;
    logic [RW-1:0]  sreg_q [2];
    logic [RW-1:0]  sreg_q_sel;

    // instruction memory, read combinationally at the program counter
    wseq_iram #(.DEPTH(DEPTH), .IW(IW)) u_iram (
        .clk      (clk),
        .we       (prog_we),
        .wr_allow (ram_wr_en),
        .waddr    (prog_addr),
        .wdata    (prog_wdata),
        .raddr    (pc[AW-1:0]),
        .rdata    (instr)
    );

    assign busy = (state != ST_IDLE);

    wseq_prescale #(.PSW(PSW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (prediv),
        .tick  (tick)
    );

    // decode fields
    assign op     = op_e'(instr[7:5]);
    assign cnt_f  = instr[IW-1:8];
    assign tgt    = instr[8+PCW-1:8];
    assign sel    = instr[4];
    assign pc_inc = {{(PCW-AW){1'b0}}, pc[AW-1:0] + AW'(1)};

    // index 0: address register, index 1: data register
    generate
        for (genvar g = 0; g < 2; g++) begin : g_sreg
            logic ld_g;
            assign ld_g = ((g == 0) ? ld_addr_we : ld_data_we) && !busy;
            wseq_shreg #(.W(RW)) u_sreg (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (ld_g),
                .load_val (ld_value),
                .shift    (sh_en && (sel == g[0])),
                .fill     (instr[3] ? 1'b0 : din),
                .q        (sreg_q[g])
            );
        end
    endgenerate

    assign addr_q     = sreg_q[0];
    assign data_q     = sreg_q[1];
    assign sreg_q_sel = sel ? sreg_q[1] : sreg_q[0];
    assign sel_msb    = sreg_q_sel[RW-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // next state and output levels
    always_comb begin
        state_n = state;
        pc_n    = pc;
        rep_n   = rep;
        sclk_n  = sclk;
        sdo_n   = sdo;
        cs_n    = cs;
        oe_n    = sdo_oe;
        sh_en   = 1'b0;
        halt    = 1'b0;
        reject  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (|start_pc[SPW-1:PCW]) begin
                        reject = 1'b1;
                    end else begin
                        pc_n    = start_pc[PCW-1:0];
                        state_n = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                if (tick) begin
                    unique case (op)
                        OP_DIRECT, OP_RSVD: begin
                            sclk_n = instr[0];
                            sdo_n  = instr[1];
                            cs_n   = instr[2];
                            oe_n   = instr[3];
                            pc_n   = pc_inc;
                        end
                        OP_TOGGLE: begin
                            sclk_n = ~sclk;
                            sdo_n  = instr[1];
                            cs_n   = instr[2];
                            oe_n   = instr[3];
                            if (cnt_f <= CW'(1)) begin
                                pc_n = pc_inc;
                            end else begin
                                rep_n   = cnt_f - CW'(1);
                                state_n = ST_REPEAT;
                            end
                        end
                        OP_SHIFT: begin
                            sclk_n = instr[0];
                            sdo_n  = instr[3] ? sel_msb : instr[1];
                            cs_n   = instr[2];
                            oe_n   = instr[3];
                            sh_en  = 1'b1;
                            if (cnt_f <= CW'(1)) begin
                                pc_n = pc_inc;
                            end else begin
                                rep_n   = cnt_f - CW'(1);
                                state_n = ST_REPEAT;
                            end
                        end
                        OP_BRZ:  pc_n = !din ? tgt : pc_inc;
                        OP_BRO:  pc_n = din ? tgt : pc_inc;
                        OP_JUMP: pc_n = tgt;
                        OP_HALT: begin
                            halt    = 1'b1;
                            state_n = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_REPEAT: begin
                if (tick) begin
                    if (op == OP_SHIFT) begin
                        sdo_n = instr[3] ? sel_msb : instr[1];
                        sh_en = 1'b1;
                    end else begin
                        sclk_n = ~sclk;
                    end
                    rep_n = rep - CW'(1);
                    if (rep == CW'(1)) begin
                        pc_n    = pc_inc;
                        state_n = ST_STEP;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc         <= '0;
            rep        <= '0;
            sclk       <= 1'b0;
            sdo        <= 1'b0;
            cs         <= 1'b1;
            sdo_oe     <= 1'b0;
            stop_pc    <= '0;
            irq_status <= '0;
        end else begin
            pc         <= pc_n;
            rep        <= rep_n;
            sclk       <= sclk_n;
            sdo        <= sdo_n;
            cs         <= cs_n;
            sdo_oe     <= oe_n;
            if (halt)
                stop_pc <= pc;
            irq_status <= (irq_status & ~irq_clr) | {reject, halt};
        end
    end

    assign irq = |(irq_status & irq_en);
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk #(
    parameter int SPW = 8,
    parameter int PCW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [SPW-1:0] start_pc,
    input logic           busy,
    input logic           tick,
    input logic           sclk,
    input logic           sdo,
    input logic           cs,
    input logic           sdo_oe,
    input logic [1:0]     irq_status
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (start_pc[SPW-1:PCW] == '0)) |=> busy);

    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (start_pc[SPW-1:PCW] != '0)) |=> (!busy && irq_status[1]));

    p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable({sclk, sdo, cs, sdo_oe}));

    p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_status[0]);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable({sclk, sdo, cs, sdo_oe}));
endmodule

bind wave_seq wseq_chk #(.SPW(SPW), .PCW(PCW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_pc   (start_pc),
    .busy       (busy),
    .tick       (tick),
    .sclk       (sclk),
    .sdo        (sdo),
    .cs         (cs),
    .sdo_oe     (sdo_oe),
    .irq_status (irq_status)
);

// File: tb/wave_seq_test.sv
module wave_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_wr_en = 1'b0;
    logic        prog_we = 1'b0;
    logic [4:0]  prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic        ld_addr_we = 1'b0;
    logic        ld_data_we = 1'b0;
    logic [15:0] ld_value = '0;
    logic        start = 1'b0;
    logic [7:0]  start_pc = '0;
    logic [7:0]  prediv = '0;
    logic        din = 1'b0;
    logic [1:0]  irq_en = 2'b00;
    logic [1:0]  irq_clr = 2'b00;
    logic        sclk, sdo, sdo_oe, cs, busy, irq;
    logic [15:0] addr_q, data_q;
    logic [5:0]  stop_pc;
    logic [1:0]  irq_status;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_seq uut (
        .clk(clk), .rst_n(rst_n), .ram_wr_en(ram_wr_en), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata), .ld_addr_we(ld_addr_we),
        .ld_data_we(ld_data_we), .ld_value(ld_value), .start(start),
        .start_pc(start_pc), .prediv(prediv), .din(din), .irq_en(irq_en),
        .irq_clr(irq_clr), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .cs(cs),
        .busy(busy), .addr_q(addr_q), .data_q(data_q), .stop_pc(stop_pc),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(int op, int cnt, int fl);
        return 16'(((cnt & 8'hff) << 8) | ((op & 7) << 5) | (fl & 8'h1f));
    endfunction

    task automatic wr(int a, logic [15:0] w, logic allow);
        @(negedge clk);
        ram_wr_en = allow; prog_we = 1'b1; prog_addr = 5'(a); prog_wdata = w;
        @(negedge clk);
        prog_we = 1'b0; ram_wr_en = 1'b0;
    endtask

    task automatic ld(logic which_data, logic [15:0] v);
        @(negedge clk);
        ld_value = v; ld_addr_we = !which_data; ld_data_we = which_data;
        @(negedge clk);
        ld_addr_we = 1'b0; ld_data_we = 1'b0;
    endtask

    task automatic run(int pc, output int cyc);
        @(negedge clk);
        start = 1'b1; start_pc = 8'(pc);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic clr_status(logic [1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = 2'b00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 busy", int'(busy), 0);
        check("R1 sclk", int'(sclk), 0);
        check("R1 sdo", int'(sdo), 0);
        check("R1 cs", int'(cs), 1);
        check("R1 oe", int'(sdo_oe), 0);
        check("R1 status", int'(irq_status), 0);
        rst_n = 1'b1;

        // R3 R4 R6: drive-mode shift sweep over prescale and count
        for (int p = 0; p < 4; p++) begin
            for (int n = 1; n <= 5; n++) begin
                int orig;
                orig = 16'hB5C3 ^ (p * 16'h0111) ^ n;
                prediv = 8'(p);
                wr(0, mk(0, 0, 5'h08), 1'b1);
                wr(1, mk(2, n, 5'h18), 1'b1);
                wr(2, mk(7, 0, 0), 1'b1);
                ld(1'b1, 16'(orig));
                ld(1'b0, 16'h5A5A);
                run(0, cyc);
                check("R3 run length", cyc, (n + 2) * (p + 1));
                check("R6 data shifted", int'(data_q), (orig << n) & 16'hFFFF);
                check("R6 sdo last msb", int'(sdo), (orig >> (16 - n)) & 1);
                check("R6 addr untouched", int'(addr_q), 16'h5A5A);
                check("R4 cs low oe high", int'({cs, sdo_oe}), 1);
                check("R9 stop_pc", int'(stop_pc), 2);
            end
        end

        // R5 toggle count sweep
        prediv = 8'd1;
        for (int n = 0; n <= 4; n++) begin
            int eff;
            eff = (n == 0) ? 1 : n;
            wr(0, mk(0, 0, 0), 1'b1);
            wr(1, mk(1, n, 5'h02), 1'b1);
            wr(2, mk(7, 0, 0), 1'b1);
            run(0, cyc);
            check("R5 toggle sclk", int'(sclk), eff & 1);
            check("R5 toggle sdo", int'(sdo), 1);
            check("R5 toggle length", cyc, (eff + 2) * 2);
        end

        // R6 input-mode shift into the address register
        prediv = 8'd0;
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 3; k++) begin
                int n, exp;
                n = (k == 0) ? 3 : (k == 1) ? 7 : 16;
                din = d[0];
                wr(0, mk(2, n, 0), 1'b1);
                wr(1, mk(7, 0, 0), 1'b1);
                ld(1'b0, 16'h1234);
                run(0, cyc);
                exp = ((32'h1234 << n) | (d != 0 ? ((1 << n) - 1) : 0)) & 16'hFFFF;
                check("R6 shift in", int'(addr_q), exp);
                check("R6 input mode oe", int'(sdo_oe), 0);
                check("R3 shift in length", cyc, n + 1);
            end
        end

        // R7 R8 branches against both data-in levels
        for (int op = 4; op <= 6; op++) begin
            for (int d = 0; d < 2; d++) begin
                int exp;
                din = d[0];
                wr(8, mk(op, 12, 0), 1'b1);
                wr(9, mk(7, 0, 0), 1'b1);
                wr(12, mk(7, 0, 0), 1'b1);
                run(8, cyc);
                if (op == 6) exp = 12;
                else if (op == 4) exp = (d == 0) ? 12 : 9;
                else exp = (d == 1) ? 12 : 9;
                check(op == 6 ? "R8 jump target" : "R7 cond branch", int'(stop_pc), exp);
                check("R7 branch length", cyc, 2);
            end
        end

        // R8 wrap from 31 to 0, R4 all levels high
        wr(31, mk(0, 0, 5'h07), 1'b1);
        wr(0, mk(7, 0, 0), 1'b1);
        run(31, cyc);
        check("R8 wrap stop_pc", int'(stop_pc), 0);
        check("R4 levels", int'({sclk, sdo, cs, sdo_oe}), 4'b1110);
        check("R9 levels held after stop", int'({sclk, sdo, cs}), 3'b111);

        // R2 start at 40 aliases word 8; R9 reports the 6-bit address
        wr(8, mk(7, 0, 0), 1'b1);
        run(40, cyc);
        check("R2 pc 40 stop_pc", int'(stop_pc), 40);
        check("R3 single step", cyc, 1);

        // R11 instruction write without permission is ignored
        wr(8, mk(0, 0, 0), 1'b0);
        run(40, cyc);
        check("R11 ram write ignored", int'(stop_pc), 40);
        check("R11 ram write ignored length", cyc, 1);

        // R10 interrupt status and clear; R2 refused start
        clr_status(2'b11);
        check("R10 cleared", int'(irq_status), 0);
        irq_en = 2'b01;
        run(40, cyc);
        @(negedge clk);
        check("R10 done flag", int'(irq_status), 1);
        check("R10 irq", int'(irq), 1);
        clr_status(2'b01);
        check("R10 clear done", int'(irq_status), 0);
        check("R10 irq low", int'(irq), 0);
        run(64, cyc);
        @(negedge clk);
        check("R2 refused busy", int'(busy), 0);
        check("R2 refused flag", int'(irq_status), 2);
        check("R10 masked", int'(irq), 0);
        irq_en = 2'b11;
        @(negedge clk);
        check("R10 unmasked", int'(irq), 1);
        clr_status(2'b11);

        // R11 loads ignored while busy
        prediv = 8'd3;
        wr(0, mk(0, 0, 5'h08), 1'b1);
        wr(1, mk(2, 4, 5'h18), 1'b1);
        wr(2, mk(7, 0, 0), 1'b1);
        ld(1'b1, 16'hAAAA);
        ld(1'b0, 16'h0F0F);
        @(negedge clk);
        start = 1'b1; start_pc = 8'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        ld_value = 16'hFFFF; ld_addr_we = 1'b1; ld_data_we = 1'b1;
        @(negedge clk);
        ld_addr_we = 1'b0; ld_data_we = 1'b0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check("R11 data not reloaded", int'(data_q), 16'hAAA0);
        check("R11 addr not reloaded", int'(addr_q), 16'h0F0F);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule